// File: doc/BRIEF.md
# Peak Detector Capture Sequencer

This block runs the amplitude channel of a two-input event timer. A comparator reports each event together with the channel it came from. An event on channel B, arriving while the sequencer is idle, turns on the external peak detector and records the coarse timestamp of that event. When the input pulse's trailing edge is reported, the block starts one conversion on the 14-bit amplitude ADC. It stores the result together with the timestamp in an output word.

The peak detector must keep its held value until both samples are taken: the amplitude conversion, and the timing-channel sample for the same channel-B event. Only then does the block hold the peak-detector reset for a programmable number of clock cycles and return to idle. The timing channel resets itself, so this block never resets it. If no trailing edge arrives within a fixed window, the capture is abandoned, an error pulse is raised and the clear phase starts at once. A channel-B event that arrives while a capture is in progress cannot be measured, and is counted as dropped.

The result leaves on a valid/ready stream. A word stays presented, unchanged, until it is accepted. While a word waits, the sequencer stays in its clear phase and does not return to idle, so back-pressure extends the dead time rather than losing or overwriting a result. With the ready input held high, each result shows as a one-cycle valid strobe.

Top module: `pkdet_capture_seq`

## Requirements
- R1: A comparator event with `cmp_chan`=1 (channel B) seen while idle raises `pd_enable` from the next cycle on. The coarse counter value at that clock edge becomes the word's stamp. The counter starts at 0 at the first edge after reset release and adds one per edge.
- R2: An event with `cmp_chan`=0 (channel A) never raises `pd_enable` and never changes `drop_cnt`. A `timing_done` with `timing_chan`=0 never releases the wait for the timing sample.
- R3: `trail_edge` seen while armed gives a single-cycle `adc_start` in the next cycle. `trail_edge` seen in any other state is ignored: there is no `adc_start` and no word.
- R4: `adc_done` during the conversion stores `adc_data` (14 bits) in `out_amp` and the event stamp in `out_stamp`, and raises `out_valid` in the next cycle.
- R5: `pd_reset` rises only after both the conversion has completed and a channel-B `timing_done` has been seen. The `timing_done` may arrive at any time from the arming cycle onward, before or after the conversion.
- R6: `pd_reset` stays high for exactly `clr_cycles` cycles, or for 1 cycle when `clr_cycles` is 0, if the output is free. `pd_enable` is low during that time, and the block is idle afterwards.
- R7: If no `trail_edge` arrives within `TIMEOUT_CYC` cycles of arming, `timeout_err` pulses for one cycle in the first cycle of `pd_reset`. No conversion is started and no word is produced.
- R8: Each channel-B event seen outside idle adds one to `drop_cnt`, which saturates at its maximum. Such an event neither changes the stamp nor starts a capture.
- R9: While `out_valid` is high and `out_ready` is low, the word holds its value and the sequencer stays in the clear phase with `pd_reset` high. The word is consumed on the first edge with `out_ready` high.
- R10: After reset, `pd_enable`, `pd_reset`, `adc_start`, `out_valid`, `timeout_err` and `drop_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_cycles | input | CLR_W | Length of the peak-detector clear phase in cycles (0 acts as 1) |
| cmp_evt | input | 1 | Comparator event pulse |
| cmp_chan | input | 1 | Channel of the event: 1 = B, 0 = A |
| trail_edge | input | 1 | Trailing edge of the input pulse |
| timing_done | input | 1 | Timing channel finished a sample |
| timing_chan | input | 1 | Channel of that timing sample: 1 = B, 0 = A |
| adc_start | output | 1 | Single-cycle conversion start for the amplitude ADC |
| adc_data | input | ADC_W | Conversion result |
| adc_done | input | 1 | Conversion result is valid |
| pd_enable | output | 1 | Peak detector enabled (capturing or holding) |
| pd_reset | output | 1 | Peak detector cleared |
| out_valid | output | 1 | Result word presented |
| out_ready | input | 1 | Consumer accepts the word |
| out_amp | output | ADC_W | Captured amplitude |
| out_stamp | output | TS_W | Coarse timestamp of the event |
| timeout_err | output | 1 | Capture abandoned because no trailing edge arrived |
| drop_cnt | output | DROP_W | Saturating count of channel-B events lost while busy |

## Verification
The bench targets the ordering of the two completions. It sends the channel-B timing sample early, late, and after a channel-A timing sample. A design that releases on the first completion, or on any channel's completion, raises `pd_reset` while the peak is still needed. It measures the clear phase for a length of 0 and a non-zero length, and for a word held by back-pressure: off-by-one counters, or a return to idle with a word still pending, show up as a wrong `pd_reset` length. It also checks the timeout cycle exactly, and checks that events during a busy capture are counted but leave the stamp of the first event intact. Trailing edges and channel-A events in idle must produce nothing.

// File: rtl/pkdet_pkg.sv
package pkdet_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CONVERT,
    ST_WAIT_TIM,
    ST_CLEAR
  } seq_state_t;
endpackage

// File: rtl/pkdet_stamp_ctr.sv
module pkdet_stamp_ctr #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/pkdet_out_slot.sv
module pkdet_out_slot #(
  parameter int ADC_W = 14,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ADC_W-1:0] amp_in,
  input  logic [TS_W-1:0]  stamp_in,
  input  logic             ready,
  output logic             valid,
  output logic [ADC_W-1:0] amp,
  output logic [TS_W-1:0]  stamp,
  output logic             free
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      amp   <= '0;
      stamp <= '0;
    end else if (load) begin
      valid <= 1'b1;
      amp   <= amp_in;
      stamp <= stamp_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assign free = !valid || ready;
endmodule

// File: rtl/pkdet_ctrl_fsm.sv
module pkdet_ctrl_fsm
  import pkdet_pkg::*;
#(
  parameter int CLR_W       = 8,
  parameter int TIMEOUT_CYC = 64,
  parameter int DROP_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CLR_W-1:0]  clr_cycles,
  input  logic              b_evt,
  input  logic              trail_edge,
  input  logic              tim_b,
  input  logic              adc_done,
  input  logic              slot_free,
  output seq_state_t        state,
  output logic              arm_take,
  output logic              load,
  output logic              adc_start,
  output logic              pd_enable,
  output logic              pd_reset,
  output logic              timeout_err,
  output logic              tim_seen,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TO_W-1:0]   TO_LAST  = TO_W'(TIMEOUT_CYC - 1);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [TO_W-1:0]  to_cnt;
  logic [CLR_W-1:0] clr_cnt;
  logic [CLR_W-1:0] clr_load;

  assign clr_load = (clr_cycles == '0) ? CLR_W'(1) : clr_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      to_cnt      <= '0;
      clr_cnt     <= '0;
      tim_seen    <= 1'b0;
      adc_start   <= 1'b0;
      timeout_err <= 1'b0;
      drop_cnt    <= '0;
    end else begin
      adc_start   <= 1'b0;
      timeout_err <= 1'b0;
      if (b_evt && state != ST_IDLE && drop_cnt != DROP_MAX)
        drop_cnt <= drop_cnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          tim_seen <= 1'b0;
          if (b_evt) begin
            state    <= ST_ARMED;
            to_cnt   <= '0;
            tim_seen <= tim_b;
          end
        end
        ST_ARMED: begin
          if (tim_b) tim_seen <= 1'b1;
          if (trail_edge) begin
            state     <= ST_CONVERT;
            adc_start <= 1'b1;
          end else if (to_cnt == TO_LAST) begin
            state       <= ST_CLEAR;
            timeout_err <= 1'b1;
            clr_cnt     <= clr_load;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        ST_CONVERT: begin
          if (tim_b) tim_seen <= 1'b1;
          if (adc_done) state <= ST_WAIT_TIM;
        end
        ST_WAIT_TIM: begin
          if (tim_seen || tim_b) begin
            state   <= ST_CLEAR;
            clr_cnt <= clr_load;
          end
        end
        ST_CLEAR: begin
          tim_seen <= 1'b0;
          if (clr_cnt <= CLR_W'(1)) begin
            if (slot_free) state <= ST_IDLE;
          end else begin
            clr_cnt <= clr_cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign arm_take  = (state == ST_IDLE) && b_evt;
  assign load      = (state == ST_CONVERT) && adc_done;
  assign pd_enable = (state == ST_ARMED) || (state == ST_CONVERT) || (state == ST_WAIT_TIM);
  assign pd_reset  = (state == ST_CLEAR);
endmodule

// File: rtl/pkdet_capture_seq.sv
module pkdet_capture_seq
  import pkdet_pkg::*;
#(
  parameter int ADC_W       = 14,
  parameter int TS_W        = 32,
  parameter int CLR_W       = 8,
  parameter int TIMEOUT_CYC = 64,
  parameter int DROP_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CLR_W-1:0]  clr_cycles,
  input  logic              cmp_evt,
  input  logic              cmp_chan,
  input  logic              trail_edge,
  input  logic              timing_done,
  input  logic              timing_chan,
  output logic              adc_start,
  input  logic [ADC_W-1:0]  adc_data,
  input  logic              adc_done,
  output logic              pd_enable,
  output logic              pd_reset,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADC_W-1:0]  out_amp,
  output logic [TS_W-1:0]   out_stamp,
  output logic              timeout_err,
  output logic [DROP_W-1:0] drop_cnt
);
  seq_state_t      state;
  logic            b_evt, tim_b, arm_take, load, slot_free, tim_seen;
  logic [TS_W-1:0] now_cnt, evt_stamp;

  assign b_evt = cmp_evt && cmp_chan;
  assign tim_b = timing_done && timing_chan;

  pkdet_stamp_ctr #(.TS_W(TS_W)) stamp_i (
    .clk(clk), .rst_n(rst_n), .count(now_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        evt_stamp <= '0;
    else if (arm_take) evt_stamp <= now_cnt;
  end

  pkdet_ctrl_fsm #(
    .CLR_W(CLR_W), .TIMEOUT_CYC(TIMEOUT_CYC), .DROP_W(DROP_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .clr_cycles(clr_cycles),
    .b_evt(b_evt), .trail_edge(trail_edge), .tim_b(tim_b),
    .adc_done(adc_done), .slot_free(slot_free),
    .state(state), .arm_take(arm_take), .load(load),
    .adc_start(adc_start), .pd_enable(pd_enable), .pd_reset(pd_reset),
    .timeout_err(timeout_err), .tim_seen(tim_seen), .drop_cnt(drop_cnt)
  );

  pkdet_out_slot #(.ADC_W(ADC_W), .TS_W(TS_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .load(load),
    .amp_in(adc_data), .stamp_in(evt_stamp), .ready(out_ready),
    .valid(out_valid), .amp(out_amp), .stamp(out_stamp), .free(slot_free)
  );
endmodule

// File: rtl/pkdet_capture_seq_chk.sv
module pkdet_capture_seq_chk #(
  parameter int ADC_W = 14,
  parameter int TS_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_evt,
  input logic             cmp_chan,
  input logic             trail_edge,
  input logic             timing_done,
  input logic             timing_chan,
  input logic             adc_start,
  input logic             pd_enable,
  input logic             pd_reset,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ADC_W-1:0] out_amp,
  input logic [TS_W-1:0]  out_stamp,
  input logic             timeout_err,
  input logic             tim_seen
);
  assert_arm_on_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_enable) |-> $past(cmp_evt && cmp_chan));

  assert_start_after_trail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(trail_edge));

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_release_after_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_reset) && !timeout_err) |-> $past(tim_seen || (timing_done && timing_chan)));

  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (pd_reset && !out_valid));

  assert_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_amp) && $stable(out_stamp)));
endmodule

bind pkdet_capture_seq pkdet_capture_seq_chk #(.ADC_W(ADC_W), .TS_W(TS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmp_evt(cmp_evt), .cmp_chan(cmp_chan),
  .trail_edge(trail_edge), .timing_done(timing_done), .timing_chan(timing_chan),
  .adc_start(adc_start), .pd_enable(pd_enable), .pd_reset(pd_reset),
  .out_valid(out_valid), .out_ready(out_ready), .out_amp(out_amp),
  .out_stamp(out_stamp), .timeout_err(timeout_err), .tim_seen(tim_seen)
);

// File: tb/pkdet_capture_seq_tb_top.sv
`timescale 1ns/1ps
module pkdet_capture_seq_tb_top;
  localparam int ADC_W = 14, TS_W = 32, CLR_W = 8, TOC = 64, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CLR_W-1:0] clr_cycles = 8'd4;
  logic cmp_evt = 0, cmp_chan = 0, trail_edge = 0, timing_done = 0, timing_chan = 0;
  logic adc_done = 0, out_ready = 1;
  logic [ADC_W-1:0] adc_data = '0;
  logic adc_start, pd_enable, pd_reset, out_valid, timeout_err;
  logic [ADC_W-1:0] out_amp;
  logic [TS_W-1:0] out_stamp;
  logic [DW-1:0] drop_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  longint tb_cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) tb_cyc <= tb_cyc + 1;

  pkdet_capture_seq #(.ADC_W(ADC_W), .TS_W(TS_W), .CLR_W(CLR_W),
                      .TIMEOUT_CYC(TOC), .DROP_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_cycles(clr_cycles), .cmp_evt(cmp_evt),
    .cmp_chan(cmp_chan), .trail_edge(trail_edge), .timing_done(timing_done),
    .timing_chan(timing_chan), .adc_start(adc_start), .adc_data(adc_data),
    .adc_done(adc_done), .pd_enable(pd_enable), .pd_reset(pd_reset),
    .out_valid(out_valid), .out_ready(out_ready), .out_amp(out_amp),
    .out_stamp(out_stamp), .timeout_err(timeout_err), .drop_cnt(drop_cnt)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // arm on channel B; returns stamp expected for this event
  task automatic arm_b(output longint st);
    cmp_evt = 1; cmp_chan = 1; st = tb_cyc;
    step();
    cmp_evt = 0; cmp_chan = 0;
  endtask

  // counts cycles with pd_reset high, starting at the current negedge
  task automatic count_clear(output int n);
    n = 0;
    while (pd_reset && n < 400) begin n++; step(); end
  endtask

  task automatic t_reset();
    chk("R10 pd_enable", pd_enable, 0);
    chk("R10 pd_reset", pd_reset, 0);
    chk("R10 adc_start", adc_start, 0);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 timeout_err", timeout_err, 0);
    chk("R10 drop_cnt", drop_cnt, 0);
  endtask

  // full capture; late=1 sends channel-B timing after the conversion
  task automatic t_capture(input logic [ADC_W-1:0] d, input int clr, input bit late);
    longint st; int n;
    clr_cycles = CLR_W'(clr);
    arm_b(st);
    chk("R1 pd_enable after B event", pd_enable, 1);
    if (!late) begin timing_done = 1; timing_chan = 1; end
    step();
    timing_done = 0; timing_chan = 0; trail_edge = 1;
    step();
    trail_edge = 0;
    chk("R3 adc_start after trail", adc_start, 1);
    step();
    chk("R3 adc_start single cycle", adc_start, 0);
    adc_data = d; adc_done = 1;
    step();
    adc_done = 0;
    chk("R4 out_valid", out_valid, 1);
    chk("R4 out_amp", out_amp, d);
    chk("R4 out_stamp", out_stamp, st);
    chk("R5 no reset before timing", pd_reset, 0);
    if (late) begin
      timing_done = 1; timing_chan = 0;
      step();
      timing_done = 0;
      step(); step();
      chk("R2 channel A timing does not release", pd_reset, 0);
      chk("R5 still holding peak", pd_enable, 1);
      timing_done = 1; timing_chan = 1;
      step();
      timing_done = 0; timing_chan = 0;
    end else begin
      step();
    end
    chk("R5 reset after both samples", pd_reset, 1);
    chk("R6 enable low in clear", pd_enable, 0);
    count_clear(n);
    chk("R6 clear length", n, (clr == 0) ? 1 : clr);
    chk("R6 idle after clear", pd_enable, 0);
  endtask

  task automatic t_idle_ignores();
    logic [DW-1:0] d0;
    d0 = drop_cnt;
    cmp_evt = 1; cmp_chan = 0;
    step();
    cmp_evt = 0;
    chk("R2 channel A does not arm", pd_enable, 0);
    chk("R2 channel A not dropped", drop_cnt, d0);
    trail_edge = 1;
    step();
    trail_edge = 0;
    chk("R3 trail in idle no start", adc_start, 0);
    step();
    chk("R3 trail in idle no word", out_valid, 0);
  endtask

  task automatic t_drop();
    longint st, st2; logic [DW-1:0] d0; int n;
    d0 = drop_cnt;
    clr_cycles = 8'd3;
    arm_b(st);
    step(); step();
    arm_b(st2);
    chk("R8 drop counted", drop_cnt, d0 + 1);
    cmp_evt = 1; cmp_chan = 0;
    step();
    cmp_evt = 0;
    chk("R2 A while busy not dropped", drop_cnt, d0 + 1);
    timing_done = 1; timing_chan = 1; trail_edge = 1;
    step();
    timing_done = 0; timing_chan = 0; trail_edge = 0;
    step();
    adc_data = 14'h1234; adc_done = 1;
    step();
    adc_done = 0;
    chk("R8 stamp of first event kept", out_stamp, st);
    step();
    count_clear(n);
    chk("R8 drop run clear length", n, 3);
  endtask

  task automatic t_timeout();
    longint st; int i, n; bit seen_valid;
    clr_cycles = 8'd2;
    seen_valid = 0;
    arm_b(st);
    i = 0;
    while (!timeout_err && i < 300) begin
      if (adc_start) seen_valid = 1;
      step(); i++;
    end
    chk("R7 timeout cycle", i, TOC);
    chk("R7 reset with error", pd_reset, 1);
    chk("R7 no conversion", seen_valid, 0);
    step();
    chk("R7 error single pulse", timeout_err, 0);
    chk("R7 no word", out_valid, 0);
    n = 1;
    while (pd_reset && n < 400) begin n++; step(); end
    chk("R7 clear after abort", n, 2);
  endtask

  task automatic t_backpressure();
    longint st;
    clr_cycles = 8'd2;
    out_ready = 0;
    arm_b(st);
    timing_done = 1; timing_chan = 1; trail_edge = 1;
    step();
    timing_done = 0; timing_chan = 0; trail_edge = 0;
    step();
    adc_data = 14'h3FFF; adc_done = 1;
    step();
    adc_done = 0;
    repeat (8) step();
    chk("R9 word held", out_valid, 1);
    chk("R9 amp held", out_amp, 14'h3FFF);
    chk("R9 stamp held", out_stamp, st);
    chk("R9 stays in clear", pd_reset, 1);
    out_ready = 1;
    step();
    chk("R9 consumed", out_valid, 0);
    chk("R9 back to idle", pd_reset, 0);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_capture(14'h2A5C, 4, 0);
    t_capture(14'h0001, 5, 1);
    t_capture(14'h1555, 0, 0);
    t_idle_ignores();
    t_drop();
    t_timeout();
    t_backpressure();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule